// File: doc/BRIEF.md
# Low-Power Sleep Counter

A 32-bit sleep counter for an always-on domain, configured and read through a small strobe-based register port. The counter advances on rising edges of one of two slow clock sources: a nominal 1 kHz RC source or a 32 kHz source. A power-of-two prescaler thins those edges. Software picks the counting direction, and it can have the counter freeze whenever the processor is halted for debug.

Both slow sources are treated as data. Each passes through a synchroniser into the bus clock, and an edge detector turns it into a one-cycle tick. All state lives in the bus clock domain, and the counter changes only on a tick of the selected source. Starting or stopping the timer runs through a two-stage pipeline that advances only on selected ticks. The change therefore takes effect on the second selected edge after the write. The count is read as two 16-bit halves. A read of the upper half latches the lower half into a shadow register, so a following lower-half read gives a tear-free 32-bit value.

Top module: `lp_sleep_counter`

## Requirements
- R1: After reset the control register (address 0) reads 0x0000, the status register (address 3) reads 0, and the count reads 0 through addresses 1 and 2.
- R2: The control register's bit 0 is the enable. The run flag in bit 0 of the status register follows it on the second rising edge of the selected source after the write. The first of those edges leaves the run flag unchanged.
- R3: While running with direction 0, the count rises by one for every 2^N edges of the selected source, where N is control bits [7:4]. Edges are counted from the edge that set the run flag.
- R4: When control bit 1 is 1 the count falls by one per step instead, and a step down from 0 gives 0xFFFFFFFF.
- R5: A step up from 0xFFFFFFFF gives 0x00000000.
- R6: A write to the control register changes bits 1, 2 and [7:4] only when the stored enable bit is 0. Bits 0 and 3 are always written.
- R7: Control bit 2 selects the source: 0 picks the RC input and 1 picks the 32 kHz input. Edges on the other input never change the count.
- R8: When control bit 3 is 1 and the halt input is high, the count and the prescaler hold. When bit 3 is 0, the halt input has no effect.
- R9: Reading address 1 returns count bits [31:16] and stores count bits [15:0] in a shadow. Reading address 2 returns the shadow, even after the count has moved on.
- R10: While the run flag is 0 the count holds, and the prescaler is cleared, so a restart begins a full 2^N-edge period.
- R11: Writes to addresses 1, 2 and 3 change neither the configuration, the count nor the shadow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock; all state is clocked here |
| rst_n | input | 1 | Active-low synchronous reset |
| src_rc_i | input | 1 | Slow RC clock source, sampled as data |
| src_xo_i | input | 1 | 32 kHz clock source, sampled as data |
| cpu_halted_i | input | 1 | High while the processor is halted for debug |
| bus_wr_i | input | 1 | Write strobe, one cycle per access |
| bus_rd_i | input | 1 | Read strobe, one cycle per access |
| bus_addr_i | input | 2 | Register select: 0 control, 1 count high, 2 count low shadow, 3 status |
| bus_wdata_i | input | 16 | Write data |
| bus_rdata_o | output | 16 | Read data for the selected register, combinational |

## Verification
The assertions check four things on every cycle. A locked field never moves while the timer is enabled. A count step is exactly plus or minus one in the configured direction. The count never moves while the run flag is low or while debug freeze applies. Steps and run-flag changes happen only on a tick of the selected source. The assertions also check that an upper-half read loads the shadow with the lower half of that cycle. Only the bench scenarios can show the things that depend on the sequence of events: the two-edge start and stop latency, the 2^N edge period and its restart after a disable, wrap-around in both directions, and that a stale shadow value stays readable.

// File: rtl/lpst_pkg.sv
package lpst_pkg;

   localparam int DIV_W = 4;

   typedef enum logic [1:0] {
      A_CTRL   = 2'd0,
      A_CNT_HI = 2'd1,
      A_CNT_LO = 2'd2,
      A_STAT   = 2'd3
   } lpst_addr_e;

   // control register layout, bits [7:0]
   typedef struct packed {
      logic [DIV_W-1:0] div_exp;
      logic             halt_freeze;
      logic             src_fast;
      logic             count_down;
      logic             run_req;
   } lpst_cfg_t;

endpackage

// File: rtl/lpst_edge_sync.sv
module lpst_edge_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic async_i,
   output logic rise_o
);
   logic [STAGES-1:0] sync_q;
   logic              last_q;

   if (STAGES < 2) begin : g_bad_stages
      $error("lpst_edge_sync: STAGES must be at least 2");
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sync_q <= '0;
         last_q <= 1'b0;
      end else begin
         sync_q <= {sync_q[STAGES-2:0], async_i};
         last_q <= sync_q[STAGES-1];
      end
   end

   assign rise_o = sync_q[STAGES-1] & ~last_q;
endmodule

// File: rtl/lpst_tick_gen.sv
module lpst_tick_gen
   import lpst_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick_i,
   input  logic             en_req_i,
   input  logic             freeze_i,
   input  logic [DIV_W-1:0] div_exp_i,
   output logic             run_o,
   output logic             step_o
);
   localparam int PRE_W = (1 << DIV_W) - 1;
   localparam logic [PRE_W:0] ONE = {{PRE_W{1'b0}}, 1'b1};

   logic             en_s1_q;
   logic             run_q;
   logic [PRE_W-1:0] pre_q;
   logic [PRE_W:0]   lim_w;
   logic [PRE_W-1:0] lim;
   logic             at_lim;
   logic             adv;

   assign lim_w  = (ONE << div_exp_i) - ONE;
   assign lim    = lim_w[PRE_W-1:0];
   assign at_lim = (pre_q == lim);
   assign adv    = run_q & tick_i & ~freeze_i;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         en_s1_q <= 1'b0;
         run_q   <= 1'b0;
         pre_q   <= '0;
      end else begin
         if (tick_i) begin
            en_s1_q <= en_req_i;
            run_q   <= en_s1_q;
         end
         if (!run_q)
            pre_q <= '0;
         else if (adv)
            pre_q <= at_lim ? '0 : pre_q + {{(PRE_W-1){1'b0}}, 1'b1};
      end
   end

   assign run_o  = run_q;
   assign step_o = adv & at_lim;
endmodule

// File: rtl/lpst_counter.sv
module lpst_counter #(
   parameter int CNT_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             step_i,
   input  logic             down_i,
   output logic [CNT_W-1:0] count_o
);
   localparam logic [CNT_W-1:0] UNIT = {{(CNT_W-1){1'b0}}, 1'b1};

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (!rst_n)
         cnt_q <= '0;
      else if (step_i)
         cnt_q <= down_i ? cnt_q - UNIT : cnt_q + UNIT;
   end

   assign count_o = cnt_q;
endmodule

// File: rtl/lp_sleep_counter.sv
module lp_sleep_counter
   import lpst_pkg::*;
#(
   parameter int CNT_W       = 32,
   parameter int SYNC_STAGES = 2,
   localparam int HALF_W     = CNT_W / 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              src_rc_i,
   input  logic              src_xo_i,
   input  logic              cpu_halted_i,
   input  logic              bus_wr_i,
   input  logic              bus_rd_i,
   input  logic [1:0]        bus_addr_i,
   input  logic [HALF_W-1:0] bus_wdata_i,
   output logic [HALF_W-1:0] bus_rdata_o
);
   localparam int NUM_SRC = 2;
   localparam int CFG_W   = $bits(lpst_cfg_t);

   if (CNT_W < 18 || (CNT_W % 2) != 0) begin : g_bad_width
      $error("lp_sleep_counter: CNT_W must be even and at least 18");
   end

   lpst_cfg_t        cfg_q;
   lpst_cfg_t        cfg_w;
   logic [NUM_SRC-1:0] src_vec;
   logic [NUM_SRC-1:0] src_tick;
   logic             tick_sel;
   logic             freeze;
   logic             run;
   logic             step;
   logic [CNT_W-1:0] count;
   logic [HALF_W-1:0] shadow_q;
   logic             unused_wdata;

   assign src_vec = {src_xo_i, src_rc_i};

   for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
      lpst_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
         .clk    (clk),
         .rst_n  (rst_n),
         .async_i(src_vec[s]),
         .rise_o (src_tick[s])
      );
   end

   assign tick_sel = src_tick[cfg_q.src_fast];
   assign freeze   = cfg_q.halt_freeze & cpu_halted_i;
   assign cfg_w    = lpst_cfg_t'(bus_wdata_i[CFG_W-1:0]);
   assign unused_wdata = ^bus_wdata_i[HALF_W-1:CFG_W];

   // configuration: direction, source and divider lock while enabled
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cfg_q <= '0;
      end else if (bus_wr_i && bus_addr_i == A_CTRL) begin
         cfg_q.run_req     <= cfg_w.run_req;
         cfg_q.halt_freeze <= cfg_w.halt_freeze;
         if (!cfg_q.run_req) begin
            cfg_q.count_down <= cfg_w.count_down;
            cfg_q.src_fast   <= cfg_w.src_fast;
            cfg_q.div_exp    <= cfg_w.div_exp;
         end
      end
   end

   lpst_tick_gen u_tick (
      .clk      (clk),
      .rst_n    (rst_n),
      .tick_i   (tick_sel),
      .en_req_i (cfg_q.run_req),
      .freeze_i (freeze),
      .div_exp_i(cfg_q.div_exp),
      .run_o    (run),
      .step_o   (step)
   );

   lpst_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk    (clk),
      .rst_n  (rst_n),
      .step_i (step),
      .down_i (cfg_q.count_down),
      .count_o(count)
   );

   // an upper-half read freezes the lower half for the next low read
   always_ff @(posedge clk) begin
      if (!rst_n)
         shadow_q <= '0;
      else if (bus_rd_i && bus_addr_i == A_CNT_HI)
         shadow_q <= count[HALF_W-1:0];
   end

   always_comb begin
      unique case (lpst_addr_e'(bus_addr_i))
         A_CTRL:   bus_rdata_o = {{(HALF_W-CFG_W){1'b0}}, cfg_q};
         A_CNT_HI: bus_rdata_o = count[CNT_W-1:HALF_W];
         A_CNT_LO: bus_rdata_o = shadow_q;
         default:  bus_rdata_o = {{(HALF_W-1){1'b0}}, run};
      endcase
   end
endmodule

// File: rtl/lp_sleep_counter_chk.sv
module lp_sleep_counter_chk
   import lpst_pkg::*;
#(
   parameter int CNT_W = 32,
   localparam int HALF_W = CNT_W / 2
) (
   input logic              clk,
   input logic              rst_n,
   input logic              bus_wr_i,
   input logic              bus_rd_i,
   input logic [1:0]        bus_addr_i,
   input logic              cpu_halted_i,
   input lpst_cfg_t         cfg_q,
   input logic [1:0]        src_tick,
   input logic              run,
   input logic              step,
   input logic [CNT_W-1:0]  count,
   input logic [HALF_W-1:0] shadow_q
);
   localparam logic [CNT_W-1:0] UNIT = {{(CNT_W-1){1'b0}}, 1'b1};

   assert_run_on_edge_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !src_tick[cfg_q.src_fast] |=> $stable(run));

   assert_step_up_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (step && !cfg_q.count_down) |=> count == $past(count) + UNIT);

   assert_step_down_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (step && cfg_q.count_down) |=> count == $past(count) - UNIT);

   assert_locked_fields_R6: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_q.run_req |=> ($stable(cfg_q.div_exp) && $stable(cfg_q.src_fast)
                         && $stable(cfg_q.count_down)));

   assert_step_on_selected_R7: assert property (@(posedge clk) disable iff (!rst_n)
      step |-> src_tick[cfg_q.src_fast]);

   assert_freeze_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_q.halt_freeze && cpu_halted_i) |=> $stable(count));

   assert_shadow_load_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rd_i && bus_addr_i == A_CNT_HI) |=> shadow_q == $past(count[HALF_W-1:0]));

   assert_hold_stopped_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !run |=> $stable(count));

   assert_ro_regs_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr_i && bus_addr_i != A_CTRL) |=> $stable(cfg_q));
endmodule

bind lp_sleep_counter lp_sleep_counter_chk #(.CNT_W(CNT_W)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .bus_wr_i    (bus_wr_i),
   .bus_rd_i    (bus_rd_i),
   .bus_addr_i  (bus_addr_i),
   .cpu_halted_i(cpu_halted_i),
   .cfg_q       (cfg_q),
   .src_tick    (src_tick),
   .run         (run),
   .step        (step),
   .count       (count),
   .shadow_q    (shadow_q)
);

// File: tb/lp_sleep_counter_test.sv
module lp_sleep_counter_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        src_rc = 1'b0;
   logic        src_xo = 1'b0;
   logic        halted = 1'b0;
   logic        bus_wr = 1'b0;
   logic        bus_rd = 1'b0;
   logic [1:0]  addr = 2'd0;
   logic [15:0] wdata = 16'd0;
   logic [15:0] rdata;

   logic [15:0] exp_q[$];
   string       tag_q[$];
   int          n_vec = 0;
   int          n_bad = 0;
   bit          finished = 1'b0;

   always #5 clk = ~clk;

   lp_sleep_counter uut (
      .clk         (clk),
      .rst_n       (rst_n),
      .src_rc_i    (src_rc),
      .src_xo_i    (src_xo),
      .cpu_halted_i(halted),
      .bus_wr_i    (bus_wr),
      .bus_rd_i    (bus_rd),
      .bus_addr_i  (addr),
      .bus_wdata_i (wdata),
      .bus_rdata_o (rdata)
   );

   // monitor: pop the expected item for each read and compare
   always @(negedge clk) begin
      logic [15:0] e;
      string       t;
      if (bus_rd && exp_q.size() > 0) begin
         e = exp_q.pop_front();
         t = tag_q.pop_front();
         n_vec++;
         if (rdata !== e) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", t, rdata, e);
         end
      end
   end

   task automatic wr(input logic [1:0] a, input logic [15:0] d);
      @(posedge clk); #1;
      bus_wr = 1'b1; addr = a; wdata = d;
      @(posedge clk); #1;
      bus_wr = 1'b0;
   endtask

   task automatic rd(input logic [1:0] a, input logic [15:0] v, input string tg);
      @(posedge clk); #1;
      bus_rd = 1'b1; addr = a;
      exp_q.push_back(v);
      tag_q.push_back(tg);
      @(posedge clk); #1;
      bus_rd = 1'b0;
   endtask

   task automatic chk_cnt(input logic [31:0] v, input string tg);
      rd(2'd1, v[31:16], tg);
      rd(2'd2, v[15:0], tg);
   endtask

   task automatic edges(input bit xo, input int n);
      for (int i = 0; i < n; i++) begin
         if (xo) src_xo = 1'b1; else src_rc = 1'b1;
         repeat (4) @(posedge clk);
         #1;
         src_xo = 1'b0; src_rc = 1'b0;
         repeat (4) @(posedge clk);
         #1;
      end
   endtask

   task automatic summary();
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         n_bad++;
         $display("FAIL watchdog: got timeout expected completion");
         summary();
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      @(posedge clk); #1;

      // R1 reset state
      rd(2'd0, 16'h0000, "R1 ctrl");
      rd(2'd3, 16'h0000, "R1 status");
      chk_cnt(32'h0, "R1 count");

      // R2 start latency, R3 up count at divide-by-1
      wr(2'd0, 16'h0001);
      edges(0, 1);
      rd(2'd3, 16'h0000, "R2 run after one edge");
      edges(0, 1);
      rd(2'd3, 16'h0001, "R2 run after two edges");
      chk_cnt(32'd0, "R2 no step on start edge");
      edges(0, 5);
      chk_cnt(32'd5, "R3 five steps");

      // R7 unselected source ignored
      edges(1, 3);
      chk_cnt(32'd5, "R7 other source");

      // R6 locked fields while enabled
      wr(2'd0, 16'h00F7);
      rd(2'd0, 16'h0001, "R6 locked write");

      // R8 debug freeze
      wr(2'd0, 16'h0009);
      halted = 1'b1;
      edges(0, 3);
      chk_cnt(32'd5, "R8 frozen");
      wr(2'd0, 16'h0001);
      edges(0, 2);
      chk_cnt(32'd7, "R8 halt ignored");
      halted = 1'b0;

      // R9 shadow keeps the value captured by the high read
      rd(2'd1, 16'h0000, "R9 high");
      edges(0, 3);
      rd(2'd2, 16'd7, "R9 stale shadow");
      chk_cnt(32'd10, "R9 fresh pair");

      // R11 writes to read-only addresses
      wr(2'd1, 16'hFFFF);
      wr(2'd2, 16'hFFFF);
      wr(2'd3, 16'hFFFF);
      rd(2'd0, 16'h0001, "R11 ctrl intact");
      rd(2'd2, 16'd10, "R11 shadow intact");
      chk_cnt(32'd10, "R11 count intact");

      // R2 stop latency: both draining edges still count
      wr(2'd0, 16'h0000);
      edges(0, 1);
      rd(2'd3, 16'h0001, "R2 run after one stop edge");
      edges(0, 1);
      rd(2'd3, 16'h0000, "R2 run after two stop edges");
      edges(0, 3);
      chk_cnt(32'd12, "R10 hold while stopped");

      // R6 unlocked, R4 down with divide-by-4 on fast source
      wr(2'd0, 16'h0026);
      rd(2'd0, 16'h0026, "R6 unlocked write");
      wr(2'd0, 16'h0027);
      edges(1, 2);
      edges(1, 8);
      chk_cnt(32'd10, "R4 down by 2^N");
      edges(0, 4);
      chk_cnt(32'd10, "R7 rc ignored");

      // R10 prescaler cleared on stop
      edges(1, 3);
      chk_cnt(32'd10, "R3 partial period");
      wr(2'd0, 16'h0026);
      edges(1, 2);
      chk_cnt(32'd9, "R10 drain steps");
      wr(2'd0, 16'h0027);
      edges(1, 2);
      edges(1, 3);
      chk_cnt(32'd9, "R10 prescaler restarted");
      edges(1, 1);
      chk_cnt(32'd8, "R10 full period");

      // R4 wrap below zero
      wr(2'd0, 16'h0026);
      edges(1, 2);
      chk_cnt(32'd8, "R10 stop mid period");
      wr(2'd0, 16'h0006);
      wr(2'd0, 16'h0007);
      edges(1, 2);
      edges(1, 9);
      chk_cnt(32'hFFFF_FFFF, "R4 wrap down");
      wr(2'd0, 16'h0006);
      edges(1, 2);
      chk_cnt(32'hFFFF_FFFD, "R4 drain down");

      // R5 wrap above max
      wr(2'd0, 16'h0004);
      wr(2'd0, 16'h0005);
      edges(1, 2);
      edges(1, 3);
      chk_cnt(32'h0000_0000, "R5 wrap up");

      finished = 1'b1;
      summary();
      $finish;
   end
endmodule